// File: doc/BRIEF.md
# Hash Session Command Controller

This block is the control part of a memory-mapped keyed-hash accelerator. Software reaches it through a simple register write port and a combinational read port. It holds four configuration bits: hash enable, keyed-mode enable, message byte reversal and digest byte reversal. It also holds the secret key words and the interrupt enables and pending bits. The block takes the commands that open and close a hash session.

The controller keeps a small session state: IDLE, ACTIVE (accepting message words), PROCESSING (waiting for the hashing core) and DONE (one cycle, then back to IDLE). It checks each command and message write against that state. It forwards accepted message words to a message FIFO and back-pressures the bus while that FIFO is full. It captures the digest from the core when the core reports completion.

Commands that arrive out of order are not acted on. Instead the controller records a distinct error code and raises the error interrupt. Configuration and key writes are ignored while a session is open. A start/done handshake stands in for the hashing core.

Top module: `hash_cmd_ctrl`

## Requirements
- R1: After reset the session state is IDLE (status bits [1:0] = 0), configuration, interrupt enables, pending bits, error code and key words are zero, and the outputs msgValid, coreStart, coreProcess and the three interrupt lines are low.
- R2: A write to address 0 while IDLE or DONE stores wrData[3:0] as configuration: bit 0 hash enable, bit 1 keyed mode (driven on coreHmacEn), bit 2 message byte reversal, bit 3 digest byte reversal. Address 0 reads back these bits.
- R3: A write to address 1 with bit 0 set, issued while IDLE or DONE with hash enable set, pulses coreStart in that cycle and moves to ACTIVE. Bit 1 without bit 0, issued while ACTIVE, pulses coreProcess and moves to PROCESSING. In PROCESSING, coreDone moves to DONE and captures coreDigest. DONE lasts one cycle and then returns to IDLE. Status address 6 reads the state in bits [1:0] (0 IDLE, 1 ACTIVE, 2 PROCESSING, 3 DONE) and the live FIFO-full input in bit 2.
- R4: A write to address 5 while ACTIVE with hash enable set drives msgValid in the same cycle. msgData equals wrData, or wrData with its four bytes reversed when configuration bit 2 is set.
- R5: While msgFifoFull is high, a write to address 5 sees wrReady low and has no effect. Pending bit 0 (FIFO full) is set in every cycle msgFifoFull is high.
- R6: A message write or start command while hash enable is clear forwards nothing, leaves the state unchanged and stores error code 1.
- R7: A key write (addresses 8 to 15, word index in address bits [2:0]) while ACTIVE or PROCESSING leaves the key unchanged and stores error code 2. Otherwise it updates coreKey[32*i +: 32].
- R8: A start command while ACTIVE or PROCESSING leaves the state unchanged and stores error code 3.
- R9: A message write with hash enable set while not ACTIVE forwards nothing and stores error code 4.
- R10: A configuration write while ACTIVE or PROCESSING is ignored and raises no error.
- R11: Pending bits (address 2: bit 0 full, bit 1 done, bit 2 error) are set by their events and cleared by writing ones to address 2. A set wins over a clear in the same cycle. Each error stores its code at address 4 and sets bit 2. Entering DONE sets bit 1. intrFull, intrDone and intrErr equal the pending bits ANDed with the enables at address 3.
- R12: Address 16+i reads digest word i, which is coreDigest[32*i +: 32] as captured on completion. The four bytes are reversed when configuration bit 3 is set at read time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write request |
| wrAddr | input | 5 | Write word address |
| wrData | input | 32 | Write data |
| wrReady | output | 1 | Low when a message write must wait for FIFO space |
| rdAddr | input | 5 | Read word address |
| rdData | output | 32 | Combinational read data |
| msgValid | output | 1 | Message word pushed to the FIFO this cycle |
| msgData | output | 32 | Message word, byte-reversed if configured |
| msgFifoFull | input | 1 | Message FIFO has no free entry |
| coreStart | output | 1 | Session opened pulse to the hashing core |
| coreProcess | output | 1 | Finalize pulse to the hashing core |
| coreHmacEn | output | 1 | Keyed mode selection for the core |
| coreKey | output | KEY_WORDS*32 | Stored key words |
| coreDone | input | 1 | Core finished; digest valid |
| coreDigest | input | DIG_WORDS*32 | Digest from the core |
| intrFull | output | 1 | FIFO-full interrupt |
| intrDone | output | 1 | Hash-done interrupt |
| intrErr | output | 1 | Error interrupt |

## Verification
The hardest situations to reach come from events that coincide. Examples are a pending-bit clear in the same cycle that the FIFO is full, or a message write that is held off by back-pressure while the session is in an error-prone state. Directed sequences set these up on purpose. Then a long seeded random mix of configuration, command, key, message and clear writes runs against a cycle-level bench model. During this mix the FIFO-full input toggles at random and core completion is pulsed only while PROCESSING. This mix reaches state/command combinations such as start in DONE, key writes during PROCESSING and clears racing error events.

// File: rtl/hash_cmd_pkg.sv
`timescale 1ns/1ps
package hash_cmd_pkg;

  localparam int ADDR_W = 5;

  localparam logic [ADDR_W-1:0] ADR_CFG    = 5'd0;
  localparam logic [ADDR_W-1:0] ADR_CMD    = 5'd1;
  localparam logic [ADDR_W-1:0] ADR_ISTATE = 5'd2;
  localparam logic [ADDR_W-1:0] ADR_IEN    = 5'd3;
  localparam logic [ADDR_W-1:0] ADR_ERR    = 5'd4;
  localparam logic [ADDR_W-1:0] ADR_MSG    = 5'd5;
  localparam logic [ADDR_W-1:0] ADR_STATUS = 5'd6;
  localparam logic [1:0]        KEY_PAGE   = 2'b01;
  localparam logic [1:0]        DIG_PAGE   = 2'b10;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_PROC   = 2'd2,
    ST_DONE   = 2'd3
  } sessState_e;

  typedef enum logic [2:0] {
    ERR_NONE         = 3'd0,
    ERR_DISABLED     = 3'd1,
    ERR_KEY_BUSY     = 3'd2,
    ERR_START_BUSY   = 3'd3,
    ERR_MSG_NO_START = 3'd4
  } errCode_e;

  typedef struct packed {
    logic     cfgWe;
    logic     keyWe;
    logic     ienWe;
    logic     istateClr;
    logic     msgPush;
    logic     errSet;
    errCode_e errCode;
    logic     doneSet;
  } ctlStrobe_t;

  function automatic logic [31:0] byteRev(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/hash_cmd_fsm.sv
`timescale 1ns/1ps
module hash_cmd_fsm
  import hash_cmd_pkg::*;
#(
  parameter int KEY_WORDS = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        cmdBits,
  input  logic              shaEn,
  input  logic              msgFifoFull,
  input  logic              coreDone,
  output logic              wrReady,
  output logic              coreStart,
  output logic              coreProcess,
  output sessState_e        state,
  output ctlStrobe_t        strobe
);

  sessState_e nextState;
  logic isCfg, isCmd, isMsg, isKey, isIen, isClr, busy, acc;

  assign isCfg = (wrAddr == ADR_CFG);
  assign isCmd = (wrAddr == ADR_CMD);
  assign isMsg = (wrAddr == ADR_MSG);
  assign isIen = (wrAddr == ADR_IEN);
  assign isClr = (wrAddr == ADR_ISTATE);
  assign isKey = (wrAddr[4:3] == KEY_PAGE) && (int'(wrAddr[2:0]) < KEY_WORDS);
  assign busy  = (state == ST_ACTIVE) || (state == ST_PROC);

  assign wrReady = !(wrEn && isMsg && msgFifoFull);
  assign acc     = wrEn && wrReady;

  always_comb begin
    nextState   = state;
    strobe      = '0;
    coreStart   = 1'b0;
    coreProcess = 1'b0;
    if (state == ST_DONE) nextState = ST_IDLE;
    if (state == ST_PROC && coreDone) begin
      nextState      = ST_DONE;
      strobe.doneSet = 1'b1;
    end
    if (acc) begin
      if (isCfg && !busy) strobe.cfgWe = 1'b1;
      if (isIen) strobe.ienWe = 1'b1;
      if (isClr) strobe.istateClr = 1'b1;
      if (isKey) begin
        if (busy) begin
          strobe.errSet  = 1'b1;
          strobe.errCode = ERR_KEY_BUSY;
        end else begin
          strobe.keyWe = 1'b1;
        end
      end
      if (isMsg) begin
        if (!shaEn) begin
          strobe.errSet  = 1'b1;
          strobe.errCode = ERR_DISABLED;
        end else if (state != ST_ACTIVE) begin
          strobe.errSet  = 1'b1;
          strobe.errCode = ERR_MSG_NO_START;
        end else begin
          strobe.msgPush = 1'b1;
        end
      end
      if (isCmd) begin
        if (cmdBits[0]) begin
          if (!shaEn) begin
            strobe.errSet  = 1'b1;
            strobe.errCode = ERR_DISABLED;
          end else if (busy) begin
            strobe.errSet  = 1'b1;
            strobe.errCode = ERR_START_BUSY;
          end else begin
            nextState = ST_ACTIVE;
            coreStart = 1'b1;
          end
        end else if (cmdBits[1] && state == ST_ACTIVE) begin
          nextState   = ST_PROC;
          coreProcess = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  // R3
  proc_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROC && !coreDone) |=> state == ST_PROC);
  // R3
  start_to_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    coreStart |=> state == ST_ACTIVE);
  // R3
  done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rstN)
    state == ST_DONE |=> state != ST_DONE);
  // R5
  no_push_when_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgFifoFull |-> !strobe.msgPush);

endmodule

// File: rtl/hash_cmd_regs.sv
`timescale 1ns/1ps
module hash_cmd_regs
  import hash_cmd_pkg::*;
#(
  parameter int KEY_WORDS = 8,
  parameter int DIG_WORDS = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  ctlStrobe_t             strobe,
  input  sessState_e             state,
  input  logic [2:0]             keyIdx,
  input  logic [31:0]            wrData,
  input  logic [ADDR_W-1:0]      rdAddr,
  output logic [31:0]            rdData,
  input  logic                   msgFifoFull,
  input  logic [DIG_WORDS*32-1:0] coreDigest,
  output logic [3:0]             cfg,
  output logic [KEY_WORDS*32-1:0] coreKey,
  output logic [31:0]            msgData,
  output logic [2:0]             intrLines
);

  logic [2:0]  ienQ;
  logic [2:0]  istateQ;
  logic [2:0]  istateNext;
  errCode_e    errQ;
  logic [31:0] keyQ [KEY_WORDS];
  logic [31:0] digQ [DIG_WORDS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             cfg <= '0;
    else if (strobe.cfgWe) cfg <= wrData[3:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ienQ <= '0;
    else if (strobe.ienWe) ienQ <= wrData[2:0];
  end

  always_comb begin
    istateNext = istateQ;
    if (strobe.istateClr) istateNext = istateNext & ~wrData[2:0];
    if (msgFifoFull)      istateNext[0] = 1'b1;
    if (strobe.doneSet)   istateNext[1] = 1'b1;
    if (strobe.errSet)    istateNext[2] = 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      istateQ <= '0;
      errQ    <= ERR_NONE;
    end else begin
      istateQ <= istateNext;
      if (strobe.errSet) errQ <= strobe.errCode;
    end
  end

  for (genvar i = 0; i < KEY_WORDS; i++) begin : g_key
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)                                       keyQ[i] <= '0;
      else if (strobe.keyWe && int'(keyIdx) == i)      keyQ[i] <= wrData;
    end
    assign coreKey[i*32 +: 32] = keyQ[i];
  end

  for (genvar j = 0; j < DIG_WORDS; j++) begin : g_dig
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)               digQ[j] <= '0;
      else if (strobe.doneSet) digQ[j] <= coreDigest[j*32 +: 32];
    end
  end

  assign msgData   = cfg[2] ? byteRev(wrData) : wrData;
  assign intrLines = istateQ & ienQ;

  always_comb begin
    rdData = '0;
    if (rdAddr == ADR_CFG)         rdData = {28'b0, cfg};
    else if (rdAddr == ADR_ISTATE) rdData = {29'b0, istateQ};
    else if (rdAddr == ADR_IEN)    rdData = {29'b0, ienQ};
    else if (rdAddr == ADR_ERR)    rdData = {29'b0, errQ};
    else if (rdAddr == ADR_STATUS) rdData = {29'b0, msgFifoFull, state};
    else if (rdAddr[4:3] == DIG_PAGE && int'(rdAddr[2:0]) < DIG_WORDS)
      rdData = cfg[3] ? byteRev(digQ[rdAddr[2:0]]) : digQ[rdAddr[2:0]];
  end

  // R11
  err_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.errSet |=> (istateQ[2] && errQ != ERR_NONE));
  // R11
  done_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doneSet |=> istateQ[1]);
  // R5
  full_pending_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgFifoFull |=> istateQ[0]);

endmodule

// File: rtl/hash_cmd_ctrl.sv
`timescale 1ns/1ps
module hash_cmd_ctrl
  import hash_cmd_pkg::*;
#(
  parameter int KEY_WORDS = 8,
  parameter int DIG_WORDS = 8
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    wrEn,
  input  logic [4:0]              wrAddr,
  input  logic [31:0]             wrData,
  output logic                    wrReady,
  input  logic [4:0]              rdAddr,
  output logic [31:0]             rdData,
  output logic                    msgValid,
  output logic [31:0]             msgData,
  input  logic                    msgFifoFull,
  output logic                    coreStart,
  output logic                    coreProcess,
  output logic                    coreHmacEn,
  output logic [KEY_WORDS*32-1:0] coreKey,
  input  logic                    coreDone,
  input  logic [DIG_WORDS*32-1:0] coreDigest,
  output logic                    intrFull,
  output logic                    intrDone,
  output logic                    intrErr
);

  ctlStrobe_t strobe;
  sessState_e state;
  logic [3:0] cfg;
  logic [2:0] intrLines;
  logic       busy;

  hash_cmd_fsm #(.KEY_WORDS(KEY_WORDS)) u_fsm (
    .clk         (clk),
    .rstN        (rstN),
    .wrEn        (wrEn),
    .wrAddr      (wrAddr),
    .cmdBits     (wrData[1:0]),
    .shaEn       (cfg[0]),
    .msgFifoFull (msgFifoFull),
    .coreDone    (coreDone),
    .wrReady     (wrReady),
    .coreStart   (coreStart),
    .coreProcess (coreProcess),
    .state       (state),
    .strobe      (strobe)
  );

  hash_cmd_regs #(.KEY_WORDS(KEY_WORDS), .DIG_WORDS(DIG_WORDS)) u_regs (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .state       (state),
    .keyIdx      (wrAddr[2:0]),
    .wrData      (wrData),
    .rdAddr      (rdAddr),
    .rdData      (rdData),
    .msgFifoFull (msgFifoFull),
    .coreDigest  (coreDigest),
    .cfg         (cfg),
    .coreKey     (coreKey),
    .msgData     (msgData),
    .intrLines   (intrLines)
  );

  assign msgValid   = strobe.msgPush;
  assign coreHmacEn = cfg[1];
  assign intrFull   = intrLines[0];
  assign intrDone   = intrLines[1];
  assign intrErr    = intrLines[2];
  assign busy       = (state == ST_ACTIVE) || (state == ST_PROC);

  // R10
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(cfg));
  // R7
  key_frozen_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(coreKey));
  // R4
  push_in_session_chk: assert property (@(posedge clk) disable iff (!rstN)
    msgValid |-> (state == ST_ACTIVE && cfg[0]));

endmodule

// File: tb/hash_cmd_ctrl_bench.sv
`timescale 1ns/1ps
module hash_cmd_ctrl_bench;

  localparam real CLK_NS = 8.0;

  logic         clk = 1'b0;
  logic         rstN;
  logic         wrEn;
  logic [4:0]   wrAddr;
  logic [31:0]  wrData;
  logic         wrReady;
  logic [4:0]   rdAddr;
  logic [31:0]  rdData;
  logic         msgValid;
  logic [31:0]  msgData;
  logic         msgFifoFull;
  logic         coreStart, coreProcess, coreHmacEn;
  logic [255:0] coreKey;
  logic         coreDone;
  logic [255:0] coreDigest;
  logic         intrFull, intrDone, intrErr;

  int checks = 0;
  int fails  = 0;

  logic [1:0]  expState;
  logic [3:0]  expCfg;
  logic [31:0] expKey [8];
  logic [31:0] expDig [8];
  logic [2:0]  expErr, expIntr, expEn;

  always #(CLK_NS/2) clk = ~clk;

  hash_cmd_ctrl u_hash_cmd_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .wrReady(wrReady), .rdAddr(rdAddr), .rdData(rdData), .msgValid(msgValid),
    .msgData(msgData), .msgFifoFull(msgFifoFull), .coreStart(coreStart),
    .coreProcess(coreProcess), .coreHmacEn(coreHmacEn), .coreKey(coreKey),
    .coreDone(coreDone), .coreDigest(coreDigest), .intrFull(intrFull),
    .intrDone(intrDone), .intrErr(intrErr)
  );

  function automatic logic [31:0] swap32(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic chk(input string tag, input string what, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  // One clock cycle of stimulus, predicted by the bench model.
  task automatic step(input string tag, input bit we, input logic [4:0] a,
                      input logic [31:0] d, input bit done, input bit ff);
    bit busy, acc, errSet, doneSet, eValid, eStart, eProc, eReady;
    logic [2:0]  code;
    logic [1:0]  ns;
    logic [31:0] eMsg;
    @(negedge clk);
    wrEn = we; wrAddr = a; wrData = d; coreDone = done; msgFifoFull = ff;
    busy   = (expState == 2'd1) || (expState == 2'd2);
    eReady = !(we && a == 5'd5 && ff);
    acc    = we && eReady;
    ns = expState; errSet = 0; doneSet = 0; code = 0;
    eValid = 0; eStart = 0; eProc = 0; eMsg = 0;
    if (expState == 2'd3) ns = 2'd0;
    if (expState == 2'd2 && done) begin ns = 2'd3; doneSet = 1; end
    if (acc) begin
      if (a == 5'd1) begin
        if (d[0]) begin
          if (!expCfg[0])  begin errSet = 1; code = 3'd1; end
          else if (busy)   begin errSet = 1; code = 3'd3; end
          else begin ns = 2'd1; eStart = 1; end
        end else if (d[1] && expState == 2'd1) begin
          ns = 2'd2; eProc = 1;
        end
      end else if (a == 5'd5) begin
        if (!expCfg[0])              begin errSet = 1; code = 3'd1; end
        else if (expState != 2'd1)   begin errSet = 1; code = 3'd4; end
        else begin eValid = 1; eMsg = expCfg[2] ? swap32(d) : d; end
      end else if (a[4:3] == 2'b01 && busy) begin
        errSet = 1; code = 3'd2;
      end
    end
    #1;
    chk(tag, "wrReady/msgValid/coreStart/coreProcess (R3 R4 R5)",
        {60'b0, wrReady, msgValid, coreStart, coreProcess},
        {60'b0, eReady, eValid, eStart, eProc});
    if (eValid) chk(tag, "msgData (R4)", {32'b0, msgData}, {32'b0, eMsg});
    // model update at the edge
    if (acc) begin
      if (a == 5'd0 && !busy) expCfg = d[3:0];
      if (a == 5'd2) expIntr = expIntr & ~d[2:0];
      if (a == 5'd3) expEn = d[2:0];
      if (a[4:3] == 2'b01 && !busy) expKey[a[2:0]] = d;
    end
    if (ff) expIntr[0] = 1'b1;
    if (doneSet) begin
      expIntr[1] = 1'b1;
      for (int i = 0; i < 8; i++) expDig[i] = coreDigest[i*32 +: 32];
    end
    if (errSet) begin expIntr[2] = 1'b1; expErr = code; end
    expState = ns;
    @(posedge clk);
    #1;
    wrEn = 1'b0; coreDone = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    rdAddr = a;
    #0.2;
    v = rdData;
  endtask

  task automatic fullCheck(input string tag);
    logic [31:0] v;
    int idx;
    rd(5'd6, v); chk(tag, "status state (R3)", {32'b0, v}, {61'b0, msgFifoFull, expState});
    rd(5'd4, v); chk(tag, "error code (R6 R7 R8 R9)", {32'b0, v}, {61'b0, expErr});
    rd(5'd0, v); chk(tag, "config (R2 R10)", {32'b0, v}, {60'b0, expCfg});
    rd(5'd2, v); chk(tag, "pending (R11)", {32'b0, v}, {61'b0, expIntr});
    rd(5'd3, v); chk(tag, "enables (R11)", {32'b0, v}, {61'b0, expEn});
    chk(tag, "intr lines (R11)", {61'b0, intrErr, intrDone, intrFull}, {61'b0, expIntr & expEn});
    chk(tag, "coreHmacEn (R2)", {63'b0, coreHmacEn}, {63'b0, expCfg[1]});
    for (int k = 0; k < 8; k++)
      chk(tag, "key word (R7)", {32'b0, coreKey[k*32 +: 32]}, {32'b0, expKey[k]});
    idx = $urandom_range(0, 7);
    rd(5'd16 + 5'(idx), v);
    chk(tag, "digest word (R12)", {32'b0, v},
        {32'b0, expCfg[3] ? swap32(expDig[idx]) : expDig[idx]});
  endtask

  task automatic newDigest();
    coreDigest = {$urandom, $urandom, $urandom, $urandom,
                  $urandom, $urandom, $urandom, $urandom};
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    void'($urandom(32'd20240611));
    rstN = 1'b0; wrEn = 0; wrAddr = 0; wrData = 0; rdAddr = 0;
    msgFifoFull = 0; coreDone = 0; coreDigest = '0;
    expState = 0; expCfg = 0; expErr = 0; expIntr = 0; expEn = 0;
    for (int i = 0; i < 8; i++) begin expKey[i] = 0; expDig[i] = 0; end
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    // R1 reset state
    fullCheck("R1");
    chk("R1", "outputs idle", {60'b0, msgValid, coreStart, coreProcess, intrErr},
        64'b0);

    // R2 configuration write and readback
    step("R2", 1, 5'd0, 32'hFFFF_FFFB, 0, 0); fullCheck("R2");
    step("R2", 1, 5'd3, 32'h7, 0, 0);
    step("R2", 1, 5'd0, 32'h5, 0, 0); fullCheck("R2");

    // R3 R4 normal session with endian swap
    for (int i = 0; i < 8; i++) step("R7", 1, 5'd8 + 5'(i), $urandom, 0, 0);
    step("R3", 1, 5'd1, 32'h1, 0, 0); fullCheck("R3");
    step("R4", 1, 5'd5, 32'h1122_3344, 0, 0);
    step("R4", 1, 5'd5, 32'hA0B0_C0D0, 0, 0);
    step("R3", 1, 5'd1, 32'h2, 0, 0); fullCheck("R3");
    newDigest();
    step("R3", 0, 5'd0, 0, 0, 0);
    step("R3", 0, 5'd0, 0, 1, 0); fullCheck("R3");
    step("R3", 0, 5'd0, 0, 0, 0); fullCheck("R3");

    // R12 digest readback plain and swapped
    for (int i = 0; i < 8; i++) begin
      rd(5'd16 + 5'(i), v); chk("R12", "digest plain", {32'b0, v}, {32'b0, expDig[i]});
    end
    step("R12", 1, 5'd0, 32'h9, 0, 0);
    for (int i = 0; i < 8; i++) begin
      rd(5'd16 + 5'(i), v); chk("R12", "digest swapped", {32'b0, v}, {32'b0, swap32(expDig[i])});
    end

    // R5 back-pressure
    step("R5", 1, 5'd1, 32'h1, 0, 0);
    step("R5", 1, 5'd5, 32'hDEAD_BEEF, 0, 1); fullCheck("R5");
    step("R5", 1, 5'd5, 32'hDEAD_BEEF, 0, 0); fullCheck("R5");
    // R8 start while active, R7 key while active, R10 config while active
    step("R8", 1, 5'd1, 32'h1, 0, 0); fullCheck("R8");
    step("R7", 1, 5'd10, 32'h1234_5678, 0, 0); fullCheck("R7");
    step("R10", 1, 5'd2, 32'h4, 0, 0);
    step("R10", 1, 5'd0, 32'h0, 0, 0); fullCheck("R10");
    step("R3", 1, 5'd1, 32'h2, 0, 0);
    step("R7", 1, 5'd11, 32'h0BAD_0BAD, 0, 0); fullCheck("R7");
    step("R8", 1, 5'd1, 32'h1, 0, 0); fullCheck("R8");
    newDigest();
    step("R3", 0, 5'd0, 0, 1, 0);
    step("R3", 0, 5'd0, 0, 0, 0); fullCheck("R3");

    // R6 disabled use
    step("R6", 1, 5'd0, 32'h0, 0, 0);
    step("R6", 1, 5'd1, 32'h1, 0, 0); fullCheck("R6");
    step("R6", 1, 5'd2, 32'h7, 0, 0);
    step("R6", 1, 5'd5, 32'h5555_AAAA, 0, 0); fullCheck("R6");
    // R9 message before start
    step("R9", 1, 5'd0, 32'h1, 0, 0);
    step("R9", 1, 5'd5, 32'h1, 0, 0); fullCheck("R9");
    // R11 clear racing a set: full event wins over clear
    step("R11", 1, 5'd2, 32'h7, 0, 1); fullCheck("R11");
    step("R11", 1, 5'd2, 32'h7, 0, 0); fullCheck("R11");
    step("R11", 1, 5'd3, 32'h5, 0, 0);
    step("R11", 1, 5'd5, 32'h1, 0, 0); fullCheck("R11");

    // Seeded random mix
    for (int n = 0; n < 900; n++) begin
      int r;
      bit done, ff;
      logic [31:0] d;
      logic [4:0]  a;
      bit we;
      r = $urandom_range(0, 11);
      we = 1; d = $urandom; a = 0;
      case (r)
        0:       begin a = 5'd0; if ($urandom_range(0, 6) != 0) d[0] = 1'b1; end
        1, 2:    begin a = 5'd1; d = 32'h1; end
        3, 4:    begin a = 5'd1; d = 32'h2; end
        5, 6, 7: a = 5'd5;
        8:       a = 5'd8 + 5'($urandom_range(0, 7));
        9:       a = 5'd2;
        10:      a = 5'd3;
        default: we = 0;
      endcase
      done = (expState == 2'd2) && ($urandom_range(0, 2) == 0);
      if (done) newDigest();
      ff = ($urandom_range(0, 4) == 0);
      step("R3 R4 R5 rnd", we, a, d, done, ff);
      fullCheck("R6 R7 R8 R9 R11 rnd");
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule